// File: doc/BRIEF.md
# Receiver Enable Seed and Delay Calculator

This block performs the per-byte-lane arithmetic around hardware-assisted DQS receiver-enable training on a memory channel with eight byte lanes. It runs in one of two modes. A start pulse picks the mode, and the block then walks the lanes in order, one lane per clock. On each step it reads that lane's inputs, which the surrounding logic provides combinationally for the lane index the block presents. The result for the lane comes out on a write port.

In seed mode, each lane's write-levelling DQS delay is added to a platform estimate. The estimate is a default constant unless an override is present for that lane. The sum, in 1/32-UI steps, is split into a gross part (sum >> 5) and a fine part (sum & 0x1F). The block writes two values for the lane:

- a phase-recovery preload that keeps only a small parity-dependent pre-gross count together with the fine part;
- a seed receiver-enable delay equal to the gross part shifted back into place.

The gross count left over after the pre-gross count is removed is kept per lane.

In finalize mode, the block reads back each lane's trained phase-recovery delay. It adds the kept gross difference and one further UI, writes the final receiver-enable delay, and tracks the largest final delay across the lanes.

Top module: `rxen_seed_calc`

## Requirements
- R1: After reset, busy, done and both write enables are low, and max_dly is 0; every stored gross difference is 0.
- R2: A start pulse is accepted only when busy is low. After acceptance, busy is high for exactly 8 cycles, and lane_idx presents 0 first and then increases by 1 each cycle up to 7. A start pulse while busy has no effect and produces no extra writes.
- R3: In seed mode, the seed total is wl_dly + 0x3B, gross = total >> 5 and fine = total & 0x1F. The pre-gross count is 1 when gross is odd and 2 when gross is even. wr_phrec carries (pregross << 5) | fine.
- R4: When ovr_en is high for a lane in seed mode, ovr_est replaces 0x3B in that lane's seed total.
- R5: In seed mode, wr_rcven carries gross << 5.
- R6: The seed total saturates at 1023 instead of wrapping. The stored difference is (gross - pregross) << 5, and it is 0 when gross is smaller than pregross.
- R7: In finalize mode, wr_rcven = phrec_rd[7:0] + (stored difference & 0x1E0) + 0x20. Bits 9:8 of phrec_rd have no effect.
- R8: In finalize mode, max_dly starts from 0 at acceptance and holds the largest final delay written so far. At done it equals the maximum over all 8 lanes. A seed run leaves it unchanged.
- R9: done is high for one cycle in each mode, in the same cycle as the lane 7 write.
- R10: The write for a lane appears on the cycle after lane_idx presented it, with wr_lane equal to that lane. wr_rcven_en is high in both modes. wr_phrec_en is high only in seed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass over all lanes |
| mode | input | 1 | Pass type: 0 seed, 1 finalize (sampled with start) |
| busy | output | 1 | A pass is stepping through the lanes |
| lane_idx | output | 3 | Lane whose inputs are read this cycle |
| wl_dly | input | 10 | Write-levelling DQS delay of lane lane_idx |
| ovr_en | input | 1 | Override estimate present for lane lane_idx |
| ovr_est | input | 10 | Override estimate for lane lane_idx |
| phrec_rd | input | 10 | Trained phase-recovery delay read back for lane lane_idx |
| wr_phrec_en | output | 1 | Phase-recovery preload write strobe |
| wr_rcven_en | output | 1 | Receiver-enable delay write strobe |
| wr_lane | output | 3 | Lane addressed by the current write |
| wr_phrec | output | 10 | Phase-recovery preload value |
| wr_rcven | output | 10 | Seed or final receiver-enable delay |
| done | output | 1 | Last lane of a pass written |
| max_dly | output | 10 | Largest final delay of the latest finalize pass |

## Verification
Lane inputs are read in the cycle lane_idx names them. The matching write, with its lane tag, is registered and becomes visible one cycle later. done and the final max_dly appear together with the lane 7 write. The bench queues the expected writes in lane order when it issues a start. It compares them at each falling edge in which a write strobe is high, so each result is checked exactly one register stage after its inputs. A write that arrives with nothing queued is reported, and so is a queue that is not empty at the end; together these catch both extra cycles and missing cycles.

// File: rtl/rxen_calc_pkg.sv
package rxen_calc_pkg;

  typedef enum logic {
    PASS_SEED  = 1'b0,
    PASS_FINAL = 1'b1
  } pass_mode_e;

  // Pre-gross count kept in the phase-recovery preload: odd gross -> 1, even -> 2.
  function automatic int unsigned pregross_of(input int unsigned gross);
    return ((gross % 2) == 1) ? 1 : 2;
  endfunction

  // Gross count left after removing the pre-gross part, floored at zero.
  function automatic int unsigned gross_gap(input int unsigned gross, input int unsigned pre);
    return (gross >= pre) ? (gross - pre) : 0;
  endfunction

  // Saturating add of two delays against a ceiling.
  function automatic int unsigned sat_sum(input int unsigned a, input int unsigned b,
                                          input int unsigned ceil);
    return ((a + b) > ceil) ? ceil : (a + b);
  endfunction

  // Final delay: low read-back part plus kept gross difference plus one UI.
  function automatic int unsigned final_sum(input int unsigned rd_low, input int unsigned gap,
                                            input int unsigned one_ui);
    return rd_low + gap + one_ui;
  endfunction

endpackage

// File: rtl/rxen_lane_seq.sv
module rxen_lane_seq
  import rxen_calc_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  pass_mode_e    mode,
  output logic          busy,
  output pass_mode_e    mode_q,
  output logic [LW-1:0] lane,
  output logic          accept,
  output logic          last
);

  assign accept = start && !busy;
  assign last   = busy && (lane == LW'(LANES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      lane   <= '0;
      mode_q <= PASS_SEED;
    end else if (accept) begin
      busy   <= 1'b1;
      lane   <= '0;
      mode_q <= mode;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      lane <= lane + LW'(1);
    end
  end

endmodule

// File: rtl/rxen_seed_unit.sv
module rxen_seed_unit
  import rxen_calc_pkg::*;
#(
  parameter int unsigned DW      = 10,
  parameter int unsigned FW      = 5,
  parameter int unsigned DEF_EST = 'h3B,
  localparam int unsigned GW     = DW - FW,
  localparam int unsigned DMAX   = (1 << DW) - 1
) (
  input  logic [DW-1:0] wl_dly,
  input  logic          ovr_en,
  input  logic [DW-1:0] ovr_est,
  output logic [DW-1:0] phrec_val,
  output logic [DW-1:0] rcven_val,
  output logic [DW-1:0] gap_val
);

  logic [DW-1:0] est;
  logic [DW-1:0] total;
  logic [GW-1:0] gross;
  logic [GW-1:0] pre;
  logic [GW-1:0] gap;
  logic [FW-1:0] fine;

  always_comb begin
    est       = ovr_en ? ovr_est : DW'(DEF_EST);
    total     = DW'(sat_sum(int'(wl_dly), int'(est), DMAX));
    gross     = total[DW-1:FW];
    fine      = total[FW-1:0];
    pre       = GW'(pregross_of(int'(gross)));
    gap       = GW'(gross_gap(int'(gross), int'(pre)));
    phrec_val = {pre, fine};
    rcven_val = {gross, {FW{1'b0}}};
    gap_val   = {gap, {FW{1'b0}}};
  end

endmodule

// File: rtl/rxen_gap_store.sv
module rxen_gap_store #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 10,
  localparam int unsigned LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] gap_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         gap_q[g] <= '0;
      else if (we && (lane == LW'(g)))    gap_q[g] <= wdata;
    end
  end

  assign rdata = gap_q[lane];

endmodule

// File: rtl/rxen_final_unit.sv
module rxen_final_unit
  import rxen_calc_pkg::*;
#(
  parameter int unsigned DW     = 10,
  parameter int unsigned FW     = 5,
  parameter int unsigned RBW    = 8,
  parameter int unsigned GMW    = 4,
  localparam logic [DW-1:0] RD_MASK  = DW'((1 << RBW) - 1),
  localparam logic [DW-1:0] GAP_MASK = DW'(((1 << GMW) - 1) << FW),
  localparam int unsigned  ONE_UI    = 1 << FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] phrec_rd,
  input  logic [DW-1:0] gap,
  input  logic          clr,
  input  logic          upd,
  output logic [DW-1:0] final_val,
  output logic [DW-1:0] max_q
);

  logic [DW-1:0] rd_low;
  logic [DW-1:0] gap_m;

  always_comb begin
    rd_low    = phrec_rd & RD_MASK;
    gap_m     = gap & GAP_MASK;
    final_val = DW'(final_sum(int'(rd_low), int'(gap_m), ONE_UI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        max_q <= '0;
    else if (clr)                      max_q <= '0;
    else if (upd && final_val > max_q) max_q <= final_val;
  end

endmodule

// File: rtl/rxen_seed_calc.sv
module rxen_seed_calc
  import rxen_calc_pkg::*;
#(
  parameter int unsigned LANES   = 8,
  parameter int unsigned DW      = 10,
  parameter int unsigned FW      = 5,
  parameter int unsigned RBW     = 8,
  parameter int unsigned GMW     = 4,
  parameter int unsigned DEF_EST = 'h3B,
  localparam int unsigned LW     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  output logic          busy,
  output logic [LW-1:0] lane_idx,
  input  logic [DW-1:0] wl_dly,
  input  logic          ovr_en,
  input  logic [DW-1:0] ovr_est,
  input  logic [DW-1:0] phrec_rd,
  output logic          wr_phrec_en,
  output logic          wr_rcven_en,
  output logic [LW-1:0] wr_lane,
  output logic [DW-1:0] wr_phrec,
  output logic [DW-1:0] wr_rcven,
  output logic          done,
  output logic [DW-1:0] max_dly
);

  pass_mode_e    mode_q;
  logic          accept_start;
  logic          lane_last;
  logic          seed_step;
  logic          final_step;
  logic          final_clr;
  logic [DW-1:0] seed_phrec;
  logic [DW-1:0] seed_rcven;
  logic [DW-1:0] seed_gap;
  logic [DW-1:0] kept_gap;
  logic [DW-1:0] fin_dly;

  rxen_lane_seq #(.LANES(LANES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (pass_mode_e'(mode)),
    .busy   (busy),
    .mode_q (mode_q),
    .lane   (lane_idx),
    .accept (accept_start),
    .last   (lane_last)
  );

  assign seed_step  = busy && (mode_q == PASS_SEED);
  assign final_step = busy && (mode_q == PASS_FINAL);
  assign final_clr  = accept_start && (pass_mode_e'(mode) == PASS_FINAL);

  rxen_seed_unit #(.DW(DW), .FW(FW), .DEF_EST(DEF_EST)) u_seed (
    .wl_dly    (wl_dly),
    .ovr_en    (ovr_en),
    .ovr_est   (ovr_est),
    .phrec_val (seed_phrec),
    .rcven_val (seed_rcven),
    .gap_val   (seed_gap)
  );

  rxen_gap_store #(.LANES(LANES), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (seed_step),
    .lane  (lane_idx),
    .wdata (seed_gap),
    .rdata (kept_gap)
  );

  rxen_final_unit #(.DW(DW), .FW(FW), .RBW(RBW), .GMW(GMW)) u_final (
    .clk       (clk),
    .rst_n     (rst_n),
    .phrec_rd  (phrec_rd),
    .gap       (kept_gap),
    .clr       (final_clr),
    .upd       (final_step),
    .final_val (fin_dly),
    .max_q     (max_dly)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_phrec_en <= 1'b0;
      wr_rcven_en <= 1'b0;
      wr_lane     <= '0;
      wr_phrec    <= '0;
      wr_rcven    <= '0;
      done        <= 1'b0;
    end else begin
      wr_phrec_en <= seed_step;
      wr_rcven_en <= busy;
      done        <= lane_last;
      if (busy) begin
        wr_lane  <= lane_idx;
        wr_phrec <= seed_phrec;
        wr_rcven <= seed_step ? seed_rcven : fin_dly;
      end
    end
  end

endmodule

// File: rtl/rxen_seed_calc_chk.sv
module rxen_seed_calc_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 10,
  parameter int unsigned FW    = 5,
  localparam int unsigned LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [LW-1:0] lane_idx,
  input logic          lane_last,
  input logic          accept_start,
  input logic          wr_phrec_en,
  input logic          wr_rcven_en,
  input logic [LW-1:0] wr_lane,
  input logic [DW-1:0] wr_phrec,
  input logic [DW-1:0] wr_rcven,
  input logic          done,
  input logic [DW-1:0] max_dly
);

  assert_start_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> busy && (lane_idx == '0));

  assert_lane_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lane_last) |=> busy && (lane_idx == $past(lane_idx) + LW'(1)));

  assert_pass_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_last |=> !busy);

  assert_pregross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phrec_en |-> (wr_phrec[FW+1:FW] == 2'b01) || (wr_phrec[FW+1:FW] == 2'b10));

  assert_preload_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phrec_en |-> (wr_phrec[DW-1:FW+2] == '0));

  assert_seed_gross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phrec_en |-> (wr_rcven[FW-1:0] == '0));

  assert_final_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rcven_en && !wr_phrec_en) |-> (wr_rcven >= DW'(1 << FW)));

  assert_max_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rcven_en && !wr_phrec_en) |-> (max_dly >= wr_rcven));

  assert_done_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_rcven_en && (wr_lane == LW'(LANES - 1)));

  assert_write_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rcven_en |-> $past(busy) && (wr_lane == $past(lane_idx)));

  assert_phrec_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phrec_en |-> wr_rcven_en);

endmodule

bind rxen_seed_calc rxen_seed_calc_chk #(.LANES(LANES), .DW(DW), .FW(FW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .lane_idx     (lane_idx),
  .lane_last    (lane_last),
  .accept_start (accept_start),
  .wr_phrec_en  (wr_phrec_en),
  .wr_rcven_en  (wr_rcven_en),
  .wr_lane      (wr_lane),
  .wr_phrec     (wr_phrec),
  .wr_rcven     (wr_rcven),
  .done         (done),
  .max_dly      (max_dly)
);

// File: tb/rxen_seed_calc_test.sv
module rxen_seed_calc_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       mode = 1'b0;
  logic       busy;
  logic [2:0] lane_idx;
  logic [9:0] wl_dly, ovr_est, phrec_rd;
  logic       ovr_en;
  logic       wr_phrec_en, wr_rcven_en, done;
  logic [2:0] wr_lane;
  logic [9:0] wr_phrec, wr_rcven, max_dly;

  always #5 clk = ~clk;

  int env_wl  [8];
  int env_ovr [8];
  bit env_oen [8];
  int env_rd  [8];
  int bgap    [8];

  assign wl_dly   = 10'(env_wl[lane_idx]);
  assign ovr_en   = env_oen[lane_idx];
  assign ovr_est  = 10'(env_ovr[lane_idx]);
  assign phrec_rd = 10'(env_rd[lane_idx]);

  rxen_seed_calc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
    .lane_idx(lane_idx), .wl_dly(wl_dly), .ovr_en(ovr_en), .ovr_est(ovr_est),
    .phrec_rd(phrec_rd), .wr_phrec_en(wr_phrec_en), .wr_rcven_en(wr_rcven_en),
    .wr_lane(wr_lane), .wr_phrec(wr_phrec), .wr_rcven(wr_rcven), .done(done),
    .max_dly(max_dly)
  );

  typedef struct {
    int    lane;
    bit    phen;
    int    phrec;
    int    rcven;
    string tag;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    errors = 0;
  int    exp_max = 0;
  int    busy_cnt = 0;
  bit    finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: computes expectations in lane order and issues the start pulse.
  task automatic run_seed(input bit poke_busy);
    for (int i = 0; i < 8; i++) begin
      item_t it;
      int est, tot, g, pre;
      est = env_oen[i] ? env_ovr[i] : 59;
      tot = env_wl[i] + est;
      if (tot > 1023) tot = 1023;
      g   = tot / 32;
      pre = (g % 2 == 1) ? 1 : 2;
      bgap[i] = (g >= pre) ? (g - pre) * 32 : 0;
      it.lane  = i;
      it.phen  = 1;
      it.phrec = pre * 32 + (tot % 32);
      it.rcven = g * 32;
      it.tag   = (env_wl[i] + est > 1023 || g < pre) ? "R6" : (env_oen[i] ? "R4" : "R3");
      sbq.push_back(it);
    end
    @(negedge clk); start = 1'b1; mode = 1'b0;
    @(negedge clk); start = 1'b0;
    if (poke_busy) begin
      // R2: a start while busy must be ignored
      @(negedge clk); start = 1'b1; mode = 1'b1;
      @(negedge clk); start = 1'b0; mode = 1'b0;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic run_final();
    exp_max = 0;
    for (int i = 0; i < 8; i++) begin
      item_t it;
      int f;
      f = (env_rd[i] % 256) + ((bgap[i] / 32) % 16) * 32 + 32;
      if (f > exp_max) exp_max = f;
      it.lane  = i;
      it.phen  = 0;
      it.phrec = 0;
      it.rcven = f;
      it.tag   = "R7";
      sbq.push_back(it);
    end
    @(negedge clk); start = 1'b1; mode = 1'b1;
    @(negedge clk); start = 1'b0; mode = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // Monitor: compares each write against the queue, one register stage after lane_idx.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (wr_rcven_en || wr_phrec_en) begin
        if (sbq.size() == 0) begin
          check(0, "R2", "unexpected write lane", int'(wr_lane), -1);
        end else begin
          item_t e;
          e = sbq.pop_front();
          check(int'(wr_lane) == e.lane, "R10", "wr_lane", int'(wr_lane), e.lane);
          check(wr_phrec_en == e.phen, "R10", "wr_phrec_en", int'(wr_phrec_en), int'(e.phen));
          check(wr_rcven_en == 1'b1, "R10", "wr_rcven_en", int'(wr_rcven_en), 1);
          if (e.phen) begin
            check(int'(wr_phrec) == e.phrec, e.tag, "wr_phrec", int'(wr_phrec), e.phrec);
            check(int'(wr_rcven) == e.rcven, "R5", "seed wr_rcven", int'(wr_rcven), e.rcven);
          end else begin
            check(int'(wr_rcven) == e.rcven, e.tag, "final wr_rcven", int'(wr_rcven), e.rcven);
          end
          check(done == (e.lane == 7), "R9", "done", int'(done), int'(e.lane == 7));
          if (e.lane == 7) begin
            check(busy_cnt == 8, "R2", "busy cycles", busy_cnt, 8);
            busy_cnt = 0;
            if (!e.phen)
              check(int'(max_dly) == exp_max, "R8", "max_dly", int'(max_dly), exp_max);
          end
        end
      end else if (done) begin
        check(0, "R9", "done without write", 1, 0);
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      env_wl[i] = 0; env_ovr[i] = 0; env_oen[i] = 0; env_rd[i] = 0; bgap[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    check(done == 1'b0, "R1", "done", int'(done), 0);
    check(wr_rcven_en == 1'b0 && wr_phrec_en == 1'b0, "R1", "write enables",
          int'({wr_phrec_en, wr_rcven_en}), 0);
    check(max_dly == 10'd0, "R1", "max_dly", int'(max_dly), 0);

    // R1/R7: finalize before any seed uses zero stored differences
    env_rd = '{10'h000, 10'h011, 10'h0FF, 10'h3FF, 10'h120, 10'h07A, 10'h200, 10'h055};
    run_final();

    // R3/R6/R2: default estimate, odd and even gross, saturation, start while busy
    env_wl = '{'h000, 'h005, 'h025, 'h040, 'h0E0, 'h1FF, 'h3E0, 'h2A1};
    run_seed(1'b1);
    check(int'(max_dly) == exp_max, "R8", "max held over seed", int'(max_dly), exp_max);

    // R7: finalize with upper read-back bits set
    env_rd = '{10'h3C4, 10'h101, 10'h2FF, 10'h010, 10'h1AB, 10'h000, 10'h3FF, 10'h080};
    run_final();

    // R4/R6: overrides, including gross below the pre-gross count
    env_wl  = '{'h010, 'h100, 'h013, 'h050, 'h3FF, 'h020, 'h010, 'h1C0};
    env_oen = '{0, 1, 0, 1, 1, 0, 1, 0};
    env_ovr = '{0, 'h07, 0, 'h200, 'h3FF, 0, 'h000, 0};
    run_seed(1'b0);

    // R8: all read-backs zero, maximum driven by stored differences
    env_rd = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_final();

    // R2: nothing left over, no stray writes
    check(sbq.size() == 0, "R2", "pending writes", sbq.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule